// File: doc/BRIEF.md
# Windowed Video Signature Checker

This block observes an RGB pixel stream, one pixel per valid cycle, marked with frame-start, line-end and frame-end flags and a per-pixel alpha-masked flag. Up to eight rectangles can be placed anywhere in the frame. For every rectangle that is switched on, it forms three 32-bit CRC signatures, one each over the red, green and blue bytes of the pixels the rectangle covers. At the end of an evaluated frame it compares each signature with a programmed expected value and raises one mismatch bit per rectangle. Display-safety logic uses it to confirm that critical screen regions carry the intended content.

Software programs the rectangles through a word-addressed write/read port. Every rectangle setting goes first into a shadow copy. The shadow copy becomes active at a later frame start, when a load request names that rectangle. A request comes either from a per-window request mask or from an external load strobe. An evaluation runs once per software kick, or on every frame when continuous mode is set.

Top module: `sigchk_top`

## Requirements
- R1: Each channel signature is a 32-bit CRC with polynomial 0x04C11DB7 and seed 0xFFFFFFFF. It processes each byte MSB first and applies no final inversion. It takes one byte per counted pixel, in raster order. Red is bits 7:0 of the pixel and blue is bits 23:16. Results are read at window offsets 8, 9 and 10 (red, green, blue). The address of a window register is window*16 + offset. After reset a result reads the seed.
- R2: Pixel X counts from 0 at the frame-start pixel and returns to 0 after a line-end pixel. Y counts lines from 0. A window covers the pixels that satisfy ulx<=x<=lrx and uly<=y<=lry, so both corners are inclusive. A window whose lower-right corner lies before its upper-left corner covers nothing, and its result stays at the seed. UL is offset 1 and LR is offset 2, with X in bits 13:0 and Y in bits 29:16.
- R3: The control register is at offset 0. Bit 0 enables the window and bit 1 enables its CRC. A window counts pixels and can flag a mismatch only when both bits are set. Otherwise its result is the seed and its mismatch bit is 0.
- R4: Control bit 2 excludes from that window any pixel whose alpha-masked flag is set.
- R5: At frame end, mismatch bit w is set if any channel result of window w differs from its expected value. The expected values for red, green and blue are at offsets 3, 4 and 5.
- R6: When continuous mode is off, only a frame that starts after a write of 1 to the kick register (0x82) is evaluated. Frames without a kick leave the results, the mismatch mask and the valid flag unchanged.
- R7: When continuous mode is on (bit 1 of mode register 0x80), every frame is evaluated.
- R8: The idle flag is low from the start of an evaluated frame through its last pixel. At the start of an evaluated frame, the valid flag and the mismatch mask clear. At the frame end, the valid flag sets.
- R9: Writes to window settings reach only the shadow copy. The shadow copy becomes active at a frame start only for windows named in a pending request. Requests are written as a mask to register 0x81.
- R10: When bit 0 of register 0x80 is set, the load request comes from a pulse on ext_load instead of the mask. A pulse loads all windows at the next frame start.
- R11: After reset the status register (0x83) reads idle=1 (bit 20), valid=0 (bit 16) and mismatch mask=0 (bits 7:0). The same three flags are also driven on dedicated ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eol | input | 1 | Last pixel of a line |
| pix_eof | input | 1 | Last pixel of a frame |
| pix_red | input | 8 | Red byte |
| pix_green | input | 8 | Green byte |
| pix_blue | input | 8 | Blue byte |
| pix_amask | input | 1 | Pixel alpha is masked |
| ext_load | input | 1 | External shadow-load strobe |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 8 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| err_mask | output | 8 | Per-window mismatch bits |
| sig_valid | output | 1 | Results of the last evaluated frame are ready |
| sig_idle | output | 1 | No evaluation in progress |

## Verification
The bound assertions check the following on every cycle:
- The flag sequencing: a completed frame sets valid and idle, and a started frame clears the flags.
- The mismatch mask and the result registers hold their values between evaluation events.
- The active window settings change only at a frame start.
- Valid is never high while an evaluation is running.

Only the bench scenarios can show the signature values themselves. This covers the corner cases: inclusive corners, inverted windows, alpha exclusion and disabled windows. It also covers whether the mask-based and strobe-based shadow loads take effect at the right frame, and the kick and continuous triggering.

// File: rtl/sigchk_pkg.sv
package sigchk_pkg;
  localparam int COORD_W = 14;
  localparam int CRC_W   = 32;
  localparam int CHAN_W  = 8;
  localparam int NCHAN   = 3;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;

  // per-window register offsets
  localparam logic [3:0] OFF_CTRL = 4'd0;
  localparam logic [3:0] OFF_UL   = 4'd1;
  localparam logic [3:0] OFF_LR   = 4'd2;
  localparam logic [3:0] OFF_REF  = 4'd3;  // 3..5
  localparam logic [3:0] OFF_RES  = 4'd8;  // 8..10
  // global register offsets
  localparam logic [3:0] G_MODE   = 4'd0;
  localparam logic [3:0] G_LDREQ  = 4'd1;
  localparam logic [3:0] G_KICK   = 4'd2;
  localparam logic [3:0] G_STATUS = 4'd3;

  typedef struct packed {
    logic [CRC_W-1:0]   ref_b;
    logic [CRC_W-1:0]   ref_g;
    logic [CRC_W-1:0]   ref_r;
    logic [COORD_W-1:0] lry;
    logic [COORD_W-1:0] lrx;
    logic [COORD_W-1:0] uly;
    logic [COORD_W-1:0] ulx;
    logic               alpha_excl;
    logic               crc_en;
    logic               win_en;
  } win_cfg_t;

  // bit-serial CRC over one byte, MSB first
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                input logic [CHAN_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = CHAN_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  function automatic logic inside_win(input win_cfg_t c,
                                      input logic [COORD_W-1:0] x,
                                      input logic [COORD_W-1:0] y);
    return (x >= c.ulx) && (x <= c.lrx) && (y >= c.uly) && (y <= c.lry);
  endfunction
endpackage

// File: rtl/sigchk_raster.sv
module sigchk_raster
  import sigchk_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_sof,
  input  logic                      in_eol,
  input  logic                      in_eof,
  input  logic [NCHAN*CHAN_W-1:0]   in_rgb,
  input  logic                      in_amask,
  output logic                      p_valid,
  output logic                      p_sof,
  output logic                      p_eof,
  output logic [COORD_W-1:0]        p_x,
  output logic [COORD_W-1:0]        p_y,
  output logic [NCHAN*CHAN_W-1:0]   p_rgb,
  output logic                      p_amask
);
  logic [COORD_W-1:0] xcnt, ycnt, pos_x, pos_y;

  assign pos_x = in_sof ? '0 : xcnt;
  assign pos_y = in_sof ? '0 : ycnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xcnt <= '0; ycnt <= '0;
      p_valid <= 1'b0; p_sof <= 1'b0; p_eof <= 1'b0;
      p_x <= '0; p_y <= '0; p_rgb <= '0; p_amask <= 1'b0;
    end else begin
      p_valid <= in_valid;
      p_sof   <= in_valid & in_sof;
      p_eof   <= in_valid & in_eof;
      if (in_valid) begin
        p_x     <= pos_x;
        p_y     <= pos_y;
        p_rgb   <= in_rgb;
        p_amask <= in_amask;
        xcnt    <= in_eol ? '0 : pos_x + COORD_W'(1);
        ycnt    <= in_eol ? pos_y + COORD_W'(1) : pos_y;
      end
    end
  end
endmodule

// File: rtl/sigchk_cfg.sv
module sigchk_cfg
  import sigchk_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int WIN_BITS = $clog2(NUM_WIN),
  localparam int ADDR_W = WIN_BITS + 5
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [ADDR_W-1:0]           cfg_addr,
  input  logic [31:0]                 cfg_wdata,
  output logic [31:0]                 cfg_rdata,
  input  logic                        frame_start,
  input  logic                        ext_load,
  input  logic [NUM_WIN*NCHAN*CRC_W-1:0] res_flat,
  input  logic [NUM_WIN-1:0]          err_mask,
  input  logic                        sig_valid,
  input  logic                        sig_idle,
  output win_cfg_t [NUM_WIN-1:0]      act_cfg,
  output logic [NUM_WIN-1:0]          load_mask,
  output logic                        cont_mode,
  output logic                        kick_pulse
);
  logic                is_glob;
  logic [WIN_BITS-1:0] win_idx;
  logic [3:0]          off;
  logic                glob_sel, ext_pend;
  logic [NUM_WIN-1:0]  ld_pend, ld_new;
  win_cfg_t            shd [NUM_WIN];
  win_cfg_t            act [NUM_WIN];

  assign is_glob = cfg_addr[ADDR_W-1];
  assign win_idx = cfg_addr[4 +: WIN_BITS];
  assign off     = cfg_addr[3:0];

  assign load_mask  = frame_start ? (glob_sel ? {NUM_WIN{ext_pend}} : ld_pend) : '0;
  assign ld_new     = (cfg_we && is_glob && off == G_LDREQ) ? cfg_wdata[NUM_WIN-1:0] : '0;
  assign kick_pulse = cfg_we && is_glob && off == G_KICK && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_sel <= 1'b0; cont_mode <= 1'b0; ext_pend <= 1'b0; ld_pend <= '0;
    end else begin
      if (cfg_we && is_glob && off == G_MODE) begin
        glob_sel  <= cfg_wdata[0];
        cont_mode <= cfg_wdata[1];
      end
      ld_pend  <= (ld_pend & ~load_mask) | ld_new;
      ext_pend <= (ext_pend & ~(frame_start & glob_sel)) | ext_load;
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd[w] <= '0;
        act[w] <= '0;
      end else begin
        if (load_mask[w]) act[w] <= shd[w];
        if (cfg_we && !is_glob && win_idx == WIN_BITS'(w)) begin
          case (off)
            OFF_CTRL: {shd[w].alpha_excl, shd[w].crc_en, shd[w].win_en} <= cfg_wdata[2:0];
            OFF_UL: begin
              shd[w].ulx <= cfg_wdata[COORD_W-1:0];
              shd[w].uly <= cfg_wdata[16 +: COORD_W];
            end
            OFF_LR: begin
              shd[w].lrx <= cfg_wdata[COORD_W-1:0];
              shd[w].lry <= cfg_wdata[16 +: COORD_W];
            end
            OFF_REF:      shd[w].ref_r <= cfg_wdata;
            OFF_REF + 1:  shd[w].ref_g <= cfg_wdata;
            OFF_REF + 2:  shd[w].ref_b <= cfg_wdata;
            default: ;
          endcase
        end
      end
    end
    assign act_cfg[w] = act[w];
  end

  always_comb begin
    cfg_rdata = '0;
    if (is_glob) begin
      case (off)
        G_MODE:   cfg_rdata[1:0] = {cont_mode, glob_sel};
        G_LDREQ:  cfg_rdata[NUM_WIN-1:0] = ld_pend;
        G_STATUS: begin
          cfg_rdata[NUM_WIN-1:0] = err_mask;
          cfg_rdata[16] = sig_valid;
          cfg_rdata[20] = sig_idle;
        end
        default: ;
      endcase
    end else begin
      case (off)
        OFF_CTRL: cfg_rdata[2:0] = {shd[win_idx].alpha_excl, shd[win_idx].crc_en, shd[win_idx].win_en};
        OFF_UL: begin
          cfg_rdata[COORD_W-1:0] = shd[win_idx].ulx;
          cfg_rdata[16 +: COORD_W] = shd[win_idx].uly;
        end
        OFF_LR: begin
          cfg_rdata[COORD_W-1:0] = shd[win_idx].lrx;
          cfg_rdata[16 +: COORD_W] = shd[win_idx].lry;
        end
        OFF_REF:     cfg_rdata = shd[win_idx].ref_r;
        OFF_REF + 1: cfg_rdata = shd[win_idx].ref_g;
        OFF_REF + 2: cfg_rdata = shd[win_idx].ref_b;
        OFF_RES:     cfg_rdata = res_flat[(int'(win_idx)*NCHAN + 0)*CRC_W +: CRC_W];
        OFF_RES + 1: cfg_rdata = res_flat[(int'(win_idx)*NCHAN + 1)*CRC_W +: CRC_W];
        OFF_RES + 2: cfg_rdata = res_flat[(int'(win_idx)*NCHAN + 2)*CRC_W +: CRC_W];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sigchk_lane.sv
module sigchk_lane
  import sigchk_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  win_cfg_t                 cfg,
  input  logic                     p_valid,
  input  logic [COORD_W-1:0]       p_x,
  input  logic [COORD_W-1:0]       p_y,
  input  logic [NCHAN*CHAN_W-1:0]  p_rgb,
  input  logic                     p_amask,
  input  logic                     eval_start,
  input  logic                     eval_busy,
  input  logic                     eval_done,
  output logic [NCHAN*CRC_W-1:0]   res,
  output logic                     err,
  output logic                     hit
);
  logic [NCHAN*CRC_W-1:0] refs;
  logic [NCHAN-1:0]       mism;
  logic                   armed;

  assign armed = cfg.win_en & cfg.crc_en;
  assign refs  = {cfg.ref_b, cfg.ref_g, cfg.ref_r};
  assign hit   = p_valid & armed & inside_win(cfg, p_x, p_y) & ~(cfg.alpha_excl & p_amask);

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    logic [CRC_W-1:0] work, base, nxt;
    assign base    = eval_start ? CRC_SEED : work;
    assign nxt     = hit ? crc_byte(base, p_rgb[c*CHAN_W +: CHAN_W]) : base;
    assign mism[c] = nxt != refs[c*CRC_W +: CRC_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        work <= CRC_SEED;
        res[c*CRC_W +: CRC_W] <= CRC_SEED;
      end else begin
        if (eval_start || (eval_busy && p_valid)) work <= nxt;
        if (eval_done) res[c*CRC_W +: CRC_W] <= nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          err <= 1'b0;
    else if (eval_done)  err <= armed & (|mism);
    else if (eval_start) err <= 1'b0;
  end
endmodule

// File: rtl/sigchk_top.sv
module sigchk_top
  import sigchk_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int WIN_BITS = $clog2(NUM_WIN),
  localparam int ADDR_W = WIN_BITS + 5
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pix_valid,
  input  logic                 pix_sof,
  input  logic                 pix_eol,
  input  logic                 pix_eof,
  input  logic [CHAN_W-1:0]    pix_red,
  input  logic [CHAN_W-1:0]    pix_green,
  input  logic [CHAN_W-1:0]    pix_blue,
  input  logic                 pix_amask,
  input  logic                 ext_load,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  output logic [NUM_WIN-1:0]   err_mask,
  output logic                 sig_valid,
  output logic                 sig_idle
);
  logic                      p_valid, p_sof, p_eof, p_amask;
  logic [COORD_W-1:0]        p_x, p_y;
  logic [NCHAN*CHAN_W-1:0]   p_rgb;
  logic                      frame_start, eval_start, eval_done;
  logic                      busy, kick_pend, cont_mode, kick_pulse;
  win_cfg_t [NUM_WIN-1:0]    act_cfg;
  logic [NUM_WIN-1:0]        load_mask, lane_hit;
  logic [NUM_WIN*NCHAN*CRC_W-1:0] res_flat;

  assign frame_start = pix_valid & pix_sof;
  assign eval_start  = p_valid & p_sof & (cont_mode | kick_pend);
  assign eval_done   = p_valid & p_eof & (busy | eval_start);
  assign sig_idle    = ~busy;

  sigchk_raster u_raster (
    .clk(clk), .rst_n(rst_n), .in_valid(pix_valid), .in_sof(pix_sof),
    .in_eol(pix_eol), .in_eof(pix_eof), .in_rgb({pix_blue, pix_green, pix_red}),
    .in_amask(pix_amask), .p_valid(p_valid), .p_sof(p_sof), .p_eof(p_eof),
    .p_x(p_x), .p_y(p_y), .p_rgb(p_rgb), .p_amask(p_amask));

  sigchk_cfg #(.NUM_WIN(NUM_WIN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frame_start(frame_start),
    .ext_load(ext_load), .res_flat(res_flat), .err_mask(err_mask),
    .sig_valid(sig_valid), .sig_idle(sig_idle), .act_cfg(act_cfg),
    .load_mask(load_mask), .cont_mode(cont_mode), .kick_pulse(kick_pulse));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_lane
    sigchk_lane u_lane (
      .clk(clk), .rst_n(rst_n), .cfg(act_cfg[w]), .p_valid(p_valid),
      .p_x(p_x), .p_y(p_y), .p_rgb(p_rgb), .p_amask(p_amask),
      .eval_start(eval_start), .eval_busy(busy), .eval_done(eval_done),
      .res(res_flat[w*NCHAN*CRC_W +: NCHAN*CRC_W]), .err(err_mask[w]),
      .hit(lane_hit[w]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; kick_pend <= 1'b0; sig_valid <= 1'b0;
    end else begin
      kick_pend <= kick_pulse | (kick_pend & ~eval_start);
      if (eval_done) begin
        busy <= 1'b0; sig_valid <= 1'b1;
      end else if (eval_start) begin
        busy <= 1'b1; sig_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sigchk_chk.sv
module sigchk_chk
  import sigchk_pkg::*;
#(
  parameter int NUM_WIN = 8
)(
  input logic                           clk,
  input logic                           rst_n,
  input logic                           eval_start,
  input logic                           eval_done,
  input logic                           frame_start,
  input logic                           sig_valid,
  input logic                           sig_idle,
  input logic [NUM_WIN-1:0]             err_mask,
  input logic [NUM_WIN*$bits(win_cfg_t)-1:0] act_flat,
  input logic [NUM_WIN*NCHAN*CRC_W-1:0] res_flat
);
  // R8
  done_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_done |=> (sig_valid && sig_idle));
  // R8
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_start && !eval_done) |=> (!sig_valid && err_mask == '0 && !sig_idle));
  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval_start && !eval_done) |=> ($stable(err_mask) && $stable(sig_valid)));
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_done |=> $stable(res_flat));
  // R9
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_flat));
  // R8
  busy_not_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_idle |-> !sig_valid);
endmodule

bind sigchk_top sigchk_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .eval_start(eval_start), .eval_done(eval_done),
  .frame_start(frame_start), .sig_valid(sig_valid), .sig_idle(sig_idle),
  .err_mask(err_mask), .act_flat(act_cfg), .res_flat(res_flat));

// File: tb/sigchk_top_tb.sv
module sigchk_top_tb;
  localparam int NW = 8;
  localparam logic [31:0] SEED = 32'hFFFFFFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_valid = 0, pix_sof = 0, pix_eol = 0, pix_eof = 0, pix_amask = 0;
  logic [7:0] pix_red = 0, pix_green = 0, pix_blue = 0;
  logic ext_load = 0, cfg_we = 0;
  logic [7:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic [NW-1:0] err_mask;
  logic sig_valid, sig_idle;

  sigchk_top u_dut (.*);

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  logic [7:0] pr [256], pg [256], pb [256];
  logic pa [256];
  int fw, fh;
  int shd_c[NW], shd_ux[NW], shd_uy[NW], shd_lx[NW], shd_ly[NW];
  int act_c[NW], act_ux[NW], act_uy[NW], act_lx[NW], act_ly[NW];
  logic [31:0] shd_ref[NW][3], act_ref[NW][3], exp_res[NW][3];
  logic [NW-1:0] exp_err = 0, pend = 0;
  logic exp_valid = 0, glob = 0, cont = 0, kickp = 0, extp = 0;

  function automatic logic [31:0] tb_crc(logic [31:0] c, logic [7:0] d);
    logic [31:0] r = c ^ {d, 24'h0};
    for (int k = 0; k < 8; k++) r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
    return r;
  endfunction

  function automatic logic [31:0] sig_of(int c, int ux, int uy, int lx, int ly, int ch);
    logic [31:0] r = SEED;
    if (!(c[0] && c[1])) return SEED;
    for (int y = 0; y < fh; y++)
      for (int x = 0; x < fw; x++) begin
        int i = y * fw + x;
        if (x >= ux && x <= lx && y >= uy && y <= ly && !(c[2] && pa[i]))
          r = tb_crc(r, ch == 0 ? pr[i] : (ch == 1 ? pg[i] : pb[i]));
      end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic set_win(int w, int c, int ux, int uy, int lx, int ly);
    wr(8'(w * 16), 32'(c));
    wr(8'(w * 16 + 1), {2'b0, 14'(uy), 2'b0, 14'(ux)});
    wr(8'(w * 16 + 2), {2'b0, 14'(ly), 2'b0, 14'(lx)});
    shd_c[w] = c; shd_ux[w] = ux; shd_uy[w] = uy; shd_lx[w] = lx; shd_ly[w] = ly;
  endtask

  task automatic set_ref(int w, logic [31:0] r, logic [31:0] g, logic [31:0] b);
    wr(8'(w * 16 + 3), r); wr(8'(w * 16 + 4), g); wr(8'(w * 16 + 5), b);
    shd_ref[w][0] = r; shd_ref[w][1] = g; shd_ref[w][2] = b;
  endtask

  task automatic request(logic [NW-1:0] m);
    wr(8'h81, {24'h0, m}); pend |= m;
  endtask

  task automatic kick();
    wr(8'h82, 32'h1); kickp = 1;
  endtask

  task automatic set_mode(logic g, logic c);
    wr(8'h80, {30'h0, c, g}); glob = g; cont = c;
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext_load = 1; @(negedge clk); ext_load = 0; extp = 1;
  endtask

  task automatic fill(int w, int h);
    fw = w; fh = h;
    for (int i = 0; i < w * h; i++) begin
      pr[i] = 8'($urandom); pg[i] = 8'($urandom); pb[i] = 8'($urandom);
      pa[i] = 1'($urandom);
    end
  endtask

  task automatic load_win(int w);
    act_c[w] = shd_c[w]; act_ux[w] = shd_ux[w]; act_uy[w] = shd_uy[w];
    act_lx[w] = shd_lx[w]; act_ly[w] = shd_ly[w];
    for (int ch = 0; ch < 3; ch++) act_ref[w][ch] = shd_ref[w][ch];
  endtask

  task automatic run_frame(string tag);
    logic ev;
    if (glob) begin
      if (extp) begin for (int w = 0; w < NW; w++) load_win(w); extp = 0; end
    end else begin
      for (int w = 0; w < NW; w++) if (pend[w]) load_win(w);
      pend = 0;
    end
    ev = cont || kickp;
    if (ev) kickp = 0;
    for (int i = 0; i < fw * fh; i++) begin
      @(negedge clk);
      pix_valid = 1; pix_sof = (i == 0); pix_eol = ((i % fw) == fw - 1);
      pix_eof = (i == fw * fh - 1);
      pix_red = pr[i]; pix_green = pg[i]; pix_blue = pb[i]; pix_amask = pa[i];
      if (i == (fw * fh) / 2) begin
        // R8: mid-frame flags
        check({tag, " R8 idle mid-frame"}, 32'(sig_idle), 32'(!ev));
        if (ev) check({tag, " R8 valid cleared"}, 32'(sig_valid), 32'h0);
      end
    end
    @(negedge clk); pix_valid = 0; pix_sof = 0; pix_eol = 0; pix_eof = 0;
    repeat (3) @(negedge clk);
    if (ev) begin
      exp_err = 0; exp_valid = 1;
      for (int w = 0; w < NW; w++) begin
        for (int ch = 0; ch < 3; ch++) begin
          exp_res[w][ch] = sig_of(act_c[w], act_ux[w], act_uy[w], act_lx[w], act_ly[w], ch);
          if (act_c[w][0] && act_c[w][1] && exp_res[w][ch] != act_ref[w][ch]) exp_err[w] = 1;
        end
      end
    end
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    rd(8'h83, d);
    check({tag, " R8 valid"}, 32'(d[16]), 32'(exp_valid));
    check({tag, " R8 idle"}, 32'(d[20]), 32'h1);
    check({tag, " R5 mismatch mask"}, 32'(d[7:0]), 32'(exp_err));
    check({tag, " R11 port flags"}, {22'h0, sig_idle, sig_valid, err_mask}, {22'h0, 1'b1, exp_valid, exp_err});
    for (int w = 0; w < NW; w++)
      for (int ch = 0; ch < 3; ch++) begin
        rd(8'(w * 16 + 8 + ch), d);
        check($sformatf("%s R1 R2 R3 R4 win%0d ch%0d", tag, w, ch), d, exp_res[w][ch]);
      end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED1234));
    for (int w = 0; w < NW; w++) begin
      shd_c[w] = 0; shd_ux[w] = 0; shd_uy[w] = 0; shd_lx[w] = 0; shd_ly[w] = 0;
      for (int ch = 0; ch < 3; ch++) begin shd_ref[w][ch] = 0; exp_res[w][ch] = SEED; end
      load_win(w);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    rd(8'h83, d);
    check("R11 reset status", d, 32'h0010_0000);
    rd(8'h00, d);
    check("R11 reset control", d, 32'h0);
    check_all("reset");

    // directed frame: corners, empty window, alpha exclusion, disabled windows
    fill(12, 8);
    set_win(0, 3, 2, 1, 6, 4);
    set_win(1, 3, 0, 0, 11, 7);
    set_win(2, 7, 1, 1, 9, 6);
    set_win(3, 3, 8, 5, 3, 2);    // R2 inverted -> empty
    set_win(4, 1, 0, 0, 5, 5);    // R3 crc disabled
    set_win(5, 3, 11, 7, 11, 7);  // last pixel only
    set_win(6, 0, 0, 0, 11, 7);   // R3 fully disabled
    set_win(7, 3, 0, 0, 0, 0);    // first pixel only
    for (int w = 0; w < NW; w++)
      set_ref(w, sig_of(shd_c[w], shd_ux[w], shd_uy[w], shd_lx[w], shd_ly[w], 0),
                 sig_of(shd_c[w], shd_ux[w], shd_uy[w], shd_lx[w], shd_ly[w], 1) + (w == 1 ? 1 : 0),
                 sig_of(shd_c[w], shd_ux[w], shd_uy[w], shd_lx[w], shd_ly[w], 2));
    request(8'hFF);
    kick();
    run_frame("directed");
    check("R5 only window1 mismatches", 32'(err_mask), 32'h2);
    check("R2 empty window keeps seed", exp_res[3][0], SEED);
    check_all("directed");

    // R6: no kick -> frame ignored
    fill(10, 6);
    run_frame("nokick");
    check_all("R6 nokick");

    // R9: shadow write without request stays inactive
    set_win(0, 3, 0, 2, 9, 3);
    fill(10, 6);
    kick();
    run_frame("noreq");
    check_all("R9 noreq");
    request(8'h01);
    kick();
    fill(10, 6);
    run_frame("req");
    check_all("R9 req");

    // R7: continuous mode
    set_mode(0, 1);
    fill(9, 7);
    run_frame("cont1");
    check_all("R7 cont1");
    fill(8, 5);
    run_frame("cont2");
    check_all("R7 cont2");

    // R10: global load select
    set_mode(1, 1);
    set_win(1, 3, 3, 0, 4, 4);
    request(8'h02);               // not used in global mode
    fill(8, 5);
    run_frame("glob_noext");
    check_all("R10 glob without strobe");
    pulse_ext();
    fill(8, 5);
    run_frame("glob_ext");
    check_all("R10 glob with strobe");

    // constrained random windows, single-shot
    set_mode(0, 0);
    for (int it = 0; it < 6; it++) begin
      int w0 = $urandom_range(6, 16), h0 = $urandom_range(4, 12);
      for (int w = 5; w < NW; w++)
        set_win(w, $urandom_range(0, 7), $urandom_range(0, w0), $urandom_range(0, h0),
                $urandom_range(0, w0), $urandom_range(0, h0));
      request(8'hE0);
      kick();
      fill(w0, h0);
      run_frame("random");
      check_all($sformatf("R1 R6 random%0d", it));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule